// File: doc/BRIEF.md
# DMA Device-Side Transfer Controller

This block is the device half of a direct-memory transfer on a channel bus. Each transfer is a service sequence of one of three kinds: a data transfer, a fetch of the device control block, or a report of residual status. A sequence opens with a start pulse that names its kind, its direction and its size. While the sequence is open, the block drives the inbound tags toward the channel: a 3-bit storage-protection key, a direction flag and a byte/word flag. The sequence closes on a strobe. On that strobe cycle the channel presents a 4-bit error status.

The key that a data transfer carries comes from the control word taken in by the last clean control-block fetch. Every other sequence carries a zero key. While the device is in its program-load state, every sequence carries a zero key.

A channel error outside program load has three effects. The error nibble is kept for software, further transfers are stopped, and an exception interrupt is raised. Software acknowledges the interrupt, and the acknowledge clears all three. An error during program load also stops transfers. It raises nothing and records nothing, and the program-load state stays active until reset.

Top module: `dma_seq_ctrl`

## Requirements
- R1: During an open data-transfer sequence outside program load, `key_o` equals bits [10:8] of the control word that was on `ctrl_word_i` at the strobe of the most recent error-free control-block fetch. These are bits 5 to 7 when the most significant bit is counted as bit 0.
- R2: `key_o` is 000 during control-block fetch (`kind_i`=01) and residual-status (`kind_i`=10) sequences, and also while no sequence is open. A data transfer is `kind_i`=00.
- R3: While `load_o` is 1, `key_o` is 000 for every kind of sequence, even when a non-zero key is stored.
- R4: While a sequence is open, `dir_o` holds the `to_mem_i` value given at its start: 1 means input to storage and 0 means output from storage. It is 0 when no sequence is open.
- R5: While a sequence is open, `size_o` holds the `byte_i` value given at its start: 1 means a byte transfer and 0 means a word transfer. It is 0 when no sequence is open.
- R6: Outside program load, a strobe with a non-zero `status_i` has three effects from the next cycle on. `err_o` holds the nibble bit for bit: bit0 is storage data check, bit1 is invalid address, bit2 is protect check and bit3 is interface data check. `irq_o` is 1, and `halted_o` is 1.
- R7: While `halted_o` is 1, a start pulse opens no sequence. Outside program load, `ack_i` clears `halted_o`, `irq_o` and `err_o`.
- R8: During program load, a strobe with a non-zero status sets `halted_o`, and leaves `irq_o` at 0 and `err_o` at 0000. After that, `load_o` stays 1 and the block stays halted, and neither `load_exit_i` nor `ack_i` changes this.
- R9: `busy_o` rises on the clock edge that samples `start_i`. On the edge that samples `strobe_i`, `busy_o` falls and `done_o` pulses high for exactly one cycle.
- R10: A control-block fetch whose strobe carries a non-zero status leaves the stored key unchanged.
- R11: `load_enter_i` sets `load_o`. `load_exit_i` clears it when the block is not halted.
- R12: After reset `busy_o`, `done_o`, `key_o`, `dir_o`, `size_o`, `irq_o`, `halted_o`, `load_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a sequence |
| kind_i | input | 2 | Sequence kind: 00 data, 01 control fetch, 10 residual |
| to_mem_i | input | 1 | Direction for the new sequence, 1 = into storage |
| byte_i | input | 1 | Size for the new sequence, 1 = byte |
| strobe_i | input | 1 | Closes the open sequence; status and control word valid |
| status_i | input | 4 | Channel error status, sampled on the strobe |
| ctrl_word_i | input | 16 | Control word presented at a control-fetch strobe |
| ack_i | input | 1 | Software interrupt acknowledge |
| load_enter_i | input | 1 | Enter program-load state |
| load_exit_i | input | 1 | Leave program-load state |
| busy_o | output | 1 | A sequence is open |
| done_o | output | 1 | One-cycle pulse after the strobe |
| key_o | output | 3 | Inbound address-key tag |
| dir_o | output | 1 | Inbound direction tag |
| size_o | output | 1 | Inbound byte/word tag |
| irq_o | output | 1 | Exception interrupt |
| halted_o | output | 1 | Transfers stopped |
| load_o | output | 1 | Program-load line |
| err_o | output | 4 | Recorded error nibble |

## Verification
The tag logic is driven through a chain of sequences that mixes all three kinds and all four direction and size combinations. Control words are chosen so that the stored key changes between data transfers. One of them has every bit set except [10:8], which shows whether the key is taken from the right slice of the word. Directed cases then compare a channel error inside and outside program load. They check that a failed control fetch keeps the old key, that a start pulse is ignored while halted, and that acknowledge and program-load exit have an effect only in the cases where they should.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int KEY_W  = 3;
    localparam int STAT_W = 4;
    localparam int CW_W   = 16;
    localparam int KEY_LSB = 8;   // bits 5..7 counted from the MSB of a 16-bit word

    typedef enum logic [1:0] {
        KIND_DATA  = 2'b00,
        KIND_CBLK  = 2'b01,
        KIND_RESID = 2'b10
    } seq_kind_e;

    typedef struct packed {
        logic             busy;
        logic             done;
        seq_kind_e        kind;
        logic             dir;
        logic             size;
        logic [KEY_W-1:0] key;
    } seq_state_t;

    typedef struct packed {
        logic              load;
        logic              halted;
        logic              irq;
        logic [STAT_W-1:0] err;
    } err_state_t;
endpackage

// File: rtl/dsc_key_store.sv
module dsc_key_store
    import dsc_pkg::*;
#(
    parameter int W   = CW_W,
    parameter int LSB = KEY_LSB,
    parameter int KW  = KEY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [W-1:0]  word_i,
    output logic [KW-1:0] key_o
);
    localparam int MSB = LSB + KW - 1;

    logic [KW-1:0] key_d, key_q;
    logic          word_unused;

    assign word_unused = ^{word_i[W-1:MSB+1], word_i[LSB-1:0]};

    always_comb begin
        key_d = key_q;
        if (capture_i) key_d = word_i[MSB:LSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign key_o = key_q;

    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(key_q)) else $error("key changed without capture"); // R10
endmodule

// File: rtl/dsc_err_track.sv
module dsc_err_track
    import dsc_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          check_i,
    input  logic [SW-1:0] status_i,
    input  logic          ack_i,
    input  logic          enter_i,
    input  logic          exit_i,
    output logic          load_o,
    output logic          halted_o,
    output logic          irq_o,
    output logic [SW-1:0] err_o
);
    err_state_t st_d, st_q;
    logic       fault;

    assign fault = check_i && (status_i != '0);

    always_comb begin
        st_d = st_q;
        if (enter_i)                  st_d.load = 1'b1;
        else if (exit_i && !st_q.halted) st_d.load = 1'b0;
        if (ack_i && !st_q.load) begin
            st_d.halted = 1'b0;
            st_d.irq    = 1'b0;
            st_d.err    = '0;
        end
        if (fault) begin
            st_d.halted = 1'b1;
            if (!st_q.load) begin
                st_d.irq = 1'b1;
                st_d.err = status_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o   = st_q.load;
    assign halted_o = st_q.halted;
    assign irq_o    = st_q.irq;
    assign err_o    = st_q.err;

    AST_ERR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !st_q.load) |=> (irq_o && halted_o && err_o == $past(status_i)))
        else $error("normal error not recorded"); // R6
    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && st_q.load) |=> (halted_o && load_o && $stable(irq_o) && $stable(err_o)))
        else $error("load error raised state"); // R8
    AST_LOAD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.halted) |=> (load_o && halted_o))
        else $error("halted load state left"); // R8
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           kind_i,
    input  logic                 to_mem_i,
    input  logic                 byte_i,
    input  logic                 strobe_i,
    input  logic [STAT_W-1:0]    status_i,
    input  logic [CW_W-1:0]      ctrl_word_i,
    input  logic                 ack_i,
    input  logic                 load_enter_i,
    input  logic                 load_exit_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [KEY_W-1:0]     key_o,
    output logic                 dir_o,
    output logic                 size_o,
    output logic                 irq_o,
    output logic                 halted_o,
    output logic                 load_o,
    output logic [STAT_W-1:0]    err_o
);
    seq_state_t        seq_d, seq_q;
    logic              close_seq, take_word, open_seq;
    logic [KEY_W-1:0]  stored_key;

    assign close_seq = strobe_i && seq_q.busy;
    assign take_word = close_seq && (seq_q.kind == KIND_CBLK) && (status_i == '0);
    assign open_seq  = start_i && !seq_q.busy && !halted_o;

    dsc_key_store #(.W(CW_W), .LSB(KEY_LSB), .KW(KEY_W)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (take_word),
        .word_i    (ctrl_word_i),
        .key_o     (stored_key)
    );

    dsc_err_track #(.SW(STAT_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_i  (close_seq),
        .status_i (status_i),
        .ack_i    (ack_i),
        .enter_i  (load_enter_i),
        .exit_i   (load_exit_i),
        .load_o   (load_o),
        .halted_o (halted_o),
        .irq_o    (irq_o),
        .err_o    (err_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (close_seq) begin
            seq_d      = '0;
            seq_d.done = 1'b1;
        end else if (open_seq) begin
            seq_d.busy = 1'b1;
            seq_d.kind = seq_kind_e'(kind_i);
            seq_d.dir  = to_mem_i;
            seq_d.size = byte_i;
            seq_d.key  = (seq_kind_e'(kind_i) == KIND_DATA && !load_o) ? stored_key : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;
    assign key_o  = seq_q.key;
    assign dir_o  = seq_q.dir;
    assign size_o = seq_q.size;

    AST_KEY_ZERO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || seq_q.kind != KIND_DATA) |-> key_o == '0)
        else $error("non-data key not zero"); // R2
    AST_KEY_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && load_o && $stable(load_o) && $past(busy_o)) |-> key_o == '0)
        else $error("load key not zero"); // R3
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !busy_o) |=> !busy_o)
        else $error("sequence opened while halted"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than a cycle"); // R9
    AST_TAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !strobe_i) |=> ($stable(dir_o) && $stable(size_o) && $stable(key_o)))
        else $error("tags moved mid-sequence"); // R4
endmodule

// File: tb/dma_seq_ctrl_test.sv
module dma_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, to_mem_i = 0, byte_i = 0, strobe_i = 0;
    logic [1:0]  kind_i = 0;
    logic [3:0]  status_i = 0;
    logic [15:0] ctrl_word_i = 0;
    logic        ack_i = 0, load_enter_i = 0, load_exit_i = 0;
    logic        busy_o, done_o, dir_o, size_o, irq_o, halted_o, load_o;
    logic [2:0]  key_o;
    logic [3:0]  err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .to_mem_i(to_mem_i), .byte_i(byte_i), .strobe_i(strobe_i),
        .status_i(status_i), .ctrl_word_i(ctrl_word_i), .ack_i(ack_i),
        .load_enter_i(load_enter_i), .load_exit_i(load_exit_i),
        .busy_o(busy_o), .done_o(done_o), .key_o(key_o), .dir_o(dir_o),
        .size_o(size_o), .irq_o(irq_o), .halted_o(halted_o), .load_o(load_o),
        .err_o(err_o)
    );

    // kind, dir, size, ctrl word, expected key
    typedef struct packed {
        logic [1:0]  kind;
        logic        dir;
        logic        size;
        logic [15:0] cw;
        logic [2:0]  key;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 1'b0, 1'b0, 16'h0500, 3'd0},
        '{2'b00, 1'b1, 1'b0, 16'h0000, 3'd5},
        '{2'b00, 1'b0, 1'b1, 16'h0000, 3'd5},
        '{2'b10, 1'b1, 1'b1, 16'h0000, 3'd0},
        '{2'b01, 1'b1, 1'b0, 16'h0300, 3'd0},
        '{2'b00, 1'b1, 1'b1, 16'h0000, 3'd3},
        '{2'b01, 1'b0, 1'b0, 16'hF8FF, 3'd0},
        '{2'b00, 1'b0, 1'b0, 16'h0000, 3'd0},
        '{2'b01, 1'b0, 1'b1, 16'h0700, 3'd0},
        '{2'b00, 1'b1, 1'b0, 16'h0000, 3'd7}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_seq(input logic [1:0] k, input logic d, input logic s);
        @(negedge clk);
        start_i = 1; kind_i = k; to_mem_i = d; byte_i = s;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic close_seq(input logic [3:0] st, input logic [15:0] cw);
        strobe_i = 1; status_i = st; ctrl_word_i = cw;
        @(negedge clk);
        strobe_i = 0; status_i = 0; ctrl_word_i = 0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1;
        @(negedge clk);
        sig = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset", {busy_o, done_o, key_o, dir_o, size_o, irq_o, halted_o, load_o, err_o},
              16'h0000);

        // R1 R2 R4 R5 R9 table walk
        for (int i = 0; i < NV; i++) begin
            open_seq(VEC[i].kind, VEC[i].dir, VEC[i].size);
            check("R9 busy after start", busy_o, 1);
            check("R1/R2 key", key_o, VEC[i].key);
            check("R4 dir", dir_o, VEC[i].dir);
            check("R5 size", size_o, VEC[i].size);
            close_seq(4'h0, VEC[i].cw);
            check("R9 done pulse", {busy_o, done_o}, 2'b01);
            check("R2 idle tags", {key_o, dir_o, size_o}, 0);
            @(negedge clk);
            check("R9 done one cycle", done_o, 0);
        end

        // R10 failed control fetch keeps key 7
        open_seq(2'b01, 0, 0);
        close_seq(4'b0001, 16'h0200);
        check("R6 storage data check", {irq_o, halted_o, err_o}, {2'b11, 4'b0001});
        pulse(ack_i);
        check("R7 ack clears", {irq_o, halted_o, err_o}, 0);
        open_seq(2'b00, 0, 0);
        check("R10 key kept", key_o, 3'd7);
        close_seq(4'b0100, 0);
        check("R6 protect check", {irq_o, halted_o, err_o}, {2'b11, 4'b0100});

        // R7 start ignored while halted
        open_seq(2'b00, 1, 1);
        check("R7 no open when halted", {busy_o, dir_o, size_o}, 0);
        pulse(ack_i);
        check("R7 ack clears", {irq_o, halted_o, err_o}, 0);

        // R11 load enter / exit
        pulse(load_enter_i);
        check("R11 load set", load_o, 1);
        open_seq(2'b00, 1, 0);
        check("R3 key zero in load", key_o, 0);
        check("R4 dir in load", dir_o, 1);
        close_seq(4'h0, 0);
        pulse(load_exit_i);
        check("R11 load cleared", load_o, 0);
        open_seq(2'b00, 0, 0);
        check("R1 key back after load", key_o, 3'd7);
        close_seq(4'h0, 0);

        // R8 error during load
        pulse(load_enter_i);
        open_seq(2'b10, 0, 1);
        check("R3 residual key in load", key_o, 0);
        close_seq(4'b1000, 0);
        check("R8 load error", {irq_o, halted_o, load_o, err_o}, {3'b011, 4'b0000});
        pulse(load_exit_i);
        pulse(ack_i);
        check("R8 sticks after exit and ack", {irq_o, halted_o, load_o, err_o}, {3'b011, 4'b0000});
        open_seq(2'b00, 0, 0);
        check("R8 no open after load error", busy_o, 0);

        // R12 reset recovers
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 reset again", {busy_o, key_o, irq_o, halted_o, load_o, err_o}, 0);

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual hung expected finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule